// File: doc/BRIEF.md
# Motor Driver Fault Shutdown Latch

This block sits between the protection comparators of a bridge motor driver and the output stage. It receives an overcurrent flag, an over-temperature flag and a motor-supply undervoltage flag, all asynchronous. It also receives an oscillator-cycle pulse from the chopper clock divider and a standby request decoded from the step-mode pins. From these it decides whether the bridge transistors may conduct.

Each flag is first resynchronised. An overcurrent indication must then survive a qualification window of several oscillator cycles before it counts, so that switching spikes cannot trip it. A qualified overcurrent, or any over-temperature indication, sets a sticky fault. A sticky fault holds the bridge off and pulls the active-low fault indicator low. An overcurrent fault also places the driver in its standby behaviour.

Sticky faults are removed only by a standby request that coincides with an oscillator pulse, or by power-on reset. Undervoltage turns the bridge off only while it lasts and is never remembered.

Top module: `fault_guard`

## Requirements
- R1: Each fault flag passes through two synchronising flip-flops, so a flag change is seen on the outputs after the second rising clock edge and not before.
- R2: An overcurrent fault is confirmed only after the synchronised flag has stayed high across MASK_TICKS (default 4) oscillator pulses. The count restarts whenever the flag drops, so shorter bursts never trip.
- R3: A confirmed overcurrent sets `oc_trip` on the next clock. It stays set after the flag returns low and forces `drive_en` low.
- R4: A synchronised over-temperature flag sets `ot_trip` on the next clock with no qualification window. The trip stays set after the flag drops and forces `drive_en` low.
- R5: `fault_n` is 0 while `oc_trip` or `ot_trip` is set, and 1 otherwise.
- R6: A clock edge with `mode_standby` and `osc_tick` both high clears both trips and the qualification count. On that edge, clearing takes priority over a new trip.
- R7: `quiesce` is 1 while `mode_standby` is high or `oc_trip` is set. An over-temperature trip alone leaves it at 0.
- R8: While the synchronised undervoltage flag is high, `drive_en` is 0 and no trip is recorded. `drive_en` returns to 1 once the flag clears.
- R9: While `rst_n` is low, both trips are 0, `fault_n` is 1 and `drive_en` is 0.
- R10: `drive_en` is 0 whenever `mode_standby` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Logic clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| osc_tick | input | 1 | One-clock pulse per chopper oscillator cycle |
| oc_flag | input | 1 | Overcurrent comparator output, asynchronous |
| ot_flag | input | 1 | Over-temperature detector output, asynchronous |
| uv_flag | input | 1 | Motor supply below recovery level, asynchronous |
| mode_standby | input | 1 | Standby selected by the step-mode pins |
| drive_en | output | 1 | Bridge transistors may conduct |
| quiesce | output | 1 | Driver behaves as in standby |
| fault_n | output | 1 | Active-low fault indicator |
| oc_trip | output | 1 | Overcurrent fault latched |
| ot_trip | output | 1 | Over-temperature fault latched |

## Verification
An undervoltage change reaches `drive_en` two clock edges after it is driven. An over-temperature change reaches the trips and `fault_n` one edge later, at three. An overcurrent needs those three edges plus the MASK_TICKS oscillator pulses. `mode_standby` acts on `drive_en` and `quiesce` at once, and on the trips at the next edge that carries a pulse. The bench drives inputs on falling edges and samples 1.5 ns after each rising edge, so every output is compared in the cycle its delay makes it due. A behavioural model advances on the same edges and is compared every cycle. Targeted checks also pin the two-edge synchroniser delay and the glitch rejection.

// File: rtl/fault_guard_pkg.sv
package fault_guard_pkg;
  localparam int FLAG_OC = 0;
  localparam int FLAG_OT = 1;
  localparam int FLAG_UV = 2;
  localparam int NFLAGS  = 3;

  // Saturating step of the overcurrent qualification count.
  function automatic int unsigned mask_next(input int unsigned cnt, input logic tick,
                                            input int unsigned limit);
    if (tick && cnt < limit) return cnt + 1;
    return cnt;
  endfunction
endpackage

// File: rtl/flag_sync.sv
module flag_sync #(
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic stage1, stage2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage1 <= 1'b0;
        stage2 <= 1'b0;
      end else begin
        stage1 <= async_in[i];
        stage2 <= stage1;
      end
    end
    assign sync_out[i] = stage2;
  end
endmodule

// File: rtl/oc_mask.sv
module oc_mask #(
  parameter int MASK_TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic oc_sync,
  input  logic osc_tick,
  input  logic restart,
  output logic mask_full
);
  import fault_guard_pkg::*;
  localparam int CW = $clog2(MASK_TICKS + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (restart || !oc_sync) cnt_q <= '0;
    else cnt_q <= CW'(mask_next(int'(cnt_q), osc_tick, MASK_TICKS));
  end

  assign mask_full = oc_sync && (cnt_q == CW'(MASK_TICKS));
endmodule

// File: rtl/trip_latch.sv
module trip_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clear_i,
  output logic trip_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trip_o <= 1'b0;
    else if (clear_i) trip_o <= 1'b0;
    else if (set_i) trip_o <= 1'b1;
  end
endmodule

// File: rtl/fault_guard.sv
module fault_guard #(
  parameter int MASK_TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_tick,
  input  logic oc_flag,
  input  logic ot_flag,
  input  logic uv_flag,
  input  logic mode_standby,
  output logic drive_en,
  output logic quiesce,
  output logic fault_n,
  output logic oc_trip,
  output logic ot_trip
);
  import fault_guard_pkg::*;

  logic [NFLAGS-1:0] flags_s;
  logic mask_full;
  logic clear_evt;
  logic run_q;

  flag_sync #(.WIDTH(NFLAGS)) sync_i (
    .clk(clk), .rst_n(rst_n),
    .async_in({uv_flag, ot_flag, oc_flag}),
    .sync_out(flags_s)
  );

  assign clear_evt = mode_standby && osc_tick;

  oc_mask #(.MASK_TICKS(MASK_TICKS)) mask_i (
    .clk(clk), .rst_n(rst_n),
    .oc_sync(flags_s[FLAG_OC]), .osc_tick(osc_tick),
    .restart(mode_standby), .mask_full(mask_full)
  );

  trip_latch oc_lat_i (
    .clk(clk), .rst_n(rst_n),
    .set_i(mask_full), .clear_i(clear_evt), .trip_o(oc_trip)
  );

  trip_latch ot_lat_i (
    .clk(clk), .rst_n(rst_n),
    .set_i(flags_s[FLAG_OT]), .clear_i(clear_evt), .trip_o(ot_trip)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else run_q <= 1'b1;
  end

  assign fault_n  = !(oc_trip || ot_trip);
  assign quiesce  = mode_standby || oc_trip;
  assign drive_en = run_q && fault_n && !flags_s[FLAG_UV] && !mode_standby;
endmodule

// File: rtl/fault_guard_chk.sv
module fault_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic osc_tick,
  input logic mode_standby,
  input logic mask_full,
  input logic oc_trip,
  input logic ot_trip,
  input logic drive_en,
  input logic fault_n,
  input logic quiesce
);
  AST_MASK_BEFORE_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oc_trip) |-> $past(mask_full)); // R2
  AST_OC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_trip && !(mode_standby && osc_tick)) |=> oc_trip); // R3
  AST_OT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ot_trip && !(mode_standby && osc_tick)) |=> ot_trip); // R4
  AST_TRIP_BLOCKS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_trip || ot_trip) |-> (!drive_en && !fault_n)); // R5
  AST_STANDBY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_standby && osc_tick) |=> (!oc_trip && !ot_trip)); // R6
  AST_OC_QUIESCE: assert property (@(posedge clk) disable iff (!rst_n)
    oc_trip |-> quiesce); // R7
  AST_STANDBY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    mode_standby |-> !drive_en); // R10
endmodule

bind fault_guard fault_guard_chk chk_i (
  .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .mode_standby(mode_standby),
  .mask_full(mask_full), .oc_trip(oc_trip), .ot_trip(ot_trip),
  .drive_en(drive_en), .fault_n(fault_n), .quiesce(quiesce)
);

// File: tb/fault_guard_tb_top.sv
`timescale 1ns/100ps
module fault_guard_tb_top;
  localparam int MASK = 4;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_tick = 1'b0;
  logic oc_flag = 1'b0, ot_flag = 1'b0, uv_flag = 1'b0, mode_standby = 1'b0;
  logic drive_en, quiesce, fault_n, oc_trip, ot_trip;
  int checks = 0, errors = 0;
  string cur_req = "R9";

  always #2.5 clk = ~clk;

  fault_guard #(.MASK_TICKS(MASK)) dut_i (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .oc_flag(oc_flag),
    .ot_flag(ot_flag), .uv_flag(uv_flag), .mode_standby(mode_standby),
    .drive_en(drive_en), .quiesce(quiesce), .fault_n(fault_n),
    .oc_trip(oc_trip), .ot_trip(ot_trip)
  );

  // oscillator pulse every fourth clock
  int tick_div = 0;
  always @(negedge clk) begin
    tick_div = (tick_div + 1) % 4;
    osc_tick <= (tick_div == 0);
  end

  // behavioural reference: queue of raw flag samples, delay of two edges
  logic [2:0] hist[$];
  int m_cnt = 0;
  bit m_oc = 0, m_ot = 0, m_run = 0;
  logic [2:0] m_seen = 3'b000;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = {3'b000, 3'b000};
      m_cnt = 0; m_oc = 0; m_ot = 0; m_run = 0; m_seen = 3'b000;
    end else begin
      bit qual, clr;
      qual = m_seen[0] && (m_cnt >= MASK);
      clr  = mode_standby && osc_tick;
      if (mode_standby || !m_seen[0]) m_cnt = 0;
      else if (osc_tick && m_cnt < MASK) m_cnt++;
      m_oc = clr ? 0 : (m_oc || qual);
      m_ot = clr ? 0 : (m_ot || m_seen[1]);
      hist.push_back({uv_flag, ot_flag, oc_flag});
      void'(hist.pop_front());
      m_seen = hist[0];
      m_run = 1;
    end
  end

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #1.5;
    chk(cur_req, "oc_trip", oc_trip, m_oc);
    chk(cur_req, "ot_trip", ot_trip, m_ot);
    chk(cur_req, "fault_n", fault_n, !(m_oc || m_ot));
    chk(cur_req, "quiesce", quiesce, mode_standby || m_oc);
    chk(cur_req, "drive_en", drive_en,
        m_run && !m_oc && !m_ot && !m_seen[2] && !mode_standby);
  end

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic sample();
    @(posedge clk); #1.5;
  endtask

  initial begin
    fork
      begin : main
        edges(3);
        sample();
        chk("R9", "reset drive_en", drive_en, 1'b0);
        chk("R9", "reset fault_n", fault_n, 1'b1);
        @(negedge clk) rst_n = 1'b1;
        cur_req = "R8"; edges(5);
        // R1: undervoltage reaches drive_en on the second edge
        @(negedge clk) uv_flag = 1'b1;
        sample(); chk("R1", "drive_en after one edge", drive_en, 1'b1);
        sample(); chk("R1", "drive_en after two edges", drive_en, 1'b0);
        edges(10);
        chk("R8", "uv not latched", fault_n, 1'b1);
        @(negedge clk) uv_flag = 1'b0;
        edges(4);
        chk("R8", "drive resumes", drive_en, 1'b1);
        // R2: short overcurrent burst ignored
        cur_req = "R2";
        @(negedge clk) oc_flag = 1'b1;
        edges(8);
        @(negedge clk) oc_flag = 1'b0;
        edges(12);
        chk("R2", "glitch ignored", oc_trip, 1'b0);
        // R3 / R7: sustained overcurrent trips and sticks
        cur_req = "R3";
        @(negedge clk) oc_flag = 1'b1;
        edges(30);
        chk("R3", "oc trips", oc_trip, 1'b1);
        chk("R7", "quiesce on oc", quiesce, 1'b1);
        @(negedge clk) oc_flag = 1'b0;
        edges(10);
        chk("R3", "oc sticky", oc_trip, 1'b1);
        chk("R5", "fault_n low", fault_n, 1'b0);
        // R6 / R10: standby clears
        cur_req = "R6";
        @(negedge clk) mode_standby = 1'b1;
        edges(1);
        chk("R10", "standby drive off", drive_en, 1'b0);
        edges(8);
        chk("R6", "oc cleared", oc_trip, 1'b0);
        @(negedge clk) mode_standby = 1'b0;
        edges(4);
        // R4: over-temperature latches without mask
        cur_req = "R4";
        @(negedge clk) ot_flag = 1'b1;
        edges(2);
        @(negedge clk) ot_flag = 1'b0;
        edges(6);
        chk("R4", "ot sticky", ot_trip, 1'b1);
        chk("R7", "ot leaves quiesce", quiesce, 1'b0);
        // R6: clear wins while flag and standby both present
        cur_req = "R6";
        @(negedge clk) begin ot_flag = 1'b1; mode_standby = 1'b1; end
        edges(20);
        @(negedge clk) begin ot_flag = 1'b0; end
        edges(8);
        chk("R6", "ot cleared", ot_trip, 1'b0);
        @(negedge clk) mode_standby = 1'b0;
        edges(4);
        // R9: reset mid-fault
        cur_req = "R9";
        @(negedge clk) ot_flag = 1'b1;
        edges(5);
        @(negedge clk) begin ot_flag = 1'b0; rst_n = 1'b0; end
        #1;
        chk("R9", "reset clears ot", ot_trip, 1'b0);
        chk("R9", "reset drive off", drive_en, 1'b0);
        edges(4);
        @(negedge clk) rst_n = 1'b1;
        edges(6);
        chk("R9", "runs after reset", drive_en, 1'b1);
      end
      begin : watchdog
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule